// File: doc/BRIEF.md
# Programmable Clock Rate Selector

This block derives a processor's main clock from a fast, free-running base clock. An 8-bit binary divider runs on every base-clock edge. Eight candidate rates feed a selector: the undivided base clock and seven divider taps. A 3-bit rate code picks the active rate. That code sits in a small control register, which software loads from an 8-bit data bus through an active-low write strobe. The same register holds one extra flag bit, which is passed straight out for use by the display logic.

The block has a true clock output and its complement; the complement clocks the microstep counter. A halt input freezes both outputs at the level they held, while the divider keeps counting so that every tap stays in phase. For logic that runs entirely in the base domain, the block also gives a one-base-cycle enable pulse on each rising edge of the chosen rate.

Top module: `clkrate_sel`

## Requirements
- R1: A synchronous active-high reset clears the divider to 0 and sets the rate code to 7 and the flag to 0. After reset, `rate_ce` is 0 until the first edge that is not in reset.
- R2: The divider increments by one on every rising base edge that is not in reset, halted or not. It wraps from 255 to 0, so the slowest tap has a period of exactly 256 base cycles.
- R3: For rate code k from 0 to 6, while running, `clk_out` equals bit (7−k) of the divider value, counted after the most recent rising base edge. Code 0 gives base/256 and code 6 gives base/4.
- R4: For rate code 7, while running, `clk_out` follows the base clock itself: high in its high phase and low in its low phase.
- R5: On a rising base edge with `wr_n` low, bus bits [2:0] become the rate code and bus bit 3 becomes `disp_flag`. Bus bits [7:4] are ignored. With `wr_n` high, a changing bus alters neither the rate nor the flag.
- R6: `clk_out_n` is always the complement of `clk_out`.
- R7: At a rising edge where `halt` is high, both outputs take the level they would have just after that edge and keep it through every later edge that sees `halt` high. A rate write during halt is stored but does not move the outputs. On release, the outputs follow the tap of the divider, which has kept counting.
- R8: `rate_ce` is high for exactly the base cycle after each edge at which the selected tap rises, provided `halt` was low at that edge. With code 7 it is high every cycle. It is 0 after any edge that sees `halt` high.
- R9: A rate write takes effect at the same edge that loads it. From the next base cycle, `clk_out` and `rate_ce` follow the new tap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast free-running base clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_data | input | 8 | Data bus carrying the rate code and flag |
| wr_n | input | 1 | Active-low control register write strobe |
| halt | input | 1 | Freezes both clock outputs while high |
| clk_out | output | 1 | Selected main clock |
| clk_out_n | output | 1 | Complement of the main clock |
| rate_ce | output | 1 | One-base-cycle pulse per rising edge of the selected rate |
| disp_flag | output | 1 | Stored flag bit for the display logic |

## Verification
The bench steps through all eight rate codes. For each code it runs long enough to see the slowest tap wrap at least twice, and it samples both base-clock phases of every cycle. This exposes a reversed or shifted tap order, a base rate that is registered instead of passed through, and a divider that skips or repeats a count. The bench halts the block at a divided rate and at the base rate, and writes a new code during the halt. A design that let the divider stop, let the outputs jump on a write, or kept pulsing `rate_ce` during halt would drift from the arithmetic model at once. A bus that changes with the strobe high, including a change to its ignored upper bits, catches a register that loads without the strobe or takes the flag from the wrong bit.

// File: rtl/crs_pkg.sv
package crs_pkg;
  // Width of the rate code; the divider has 2**CRS_SEL_W bits, one tap per code.
  parameter int unsigned CRS_SEL_W = 3;
  localparam int unsigned CRS_NTAP = 2 ** CRS_SEL_W;

  typedef struct packed {
    logic                 flag;
    logic [CRS_SEL_W-1:0] rate;
  } crs_ctrl_t;
endpackage

// File: rtl/crs_cnt_stage.sv
module crs_cnt_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  output logic [W-1:0] q_o,
  output logic         cy_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk) begin
    if (rst)       q_r <= '0;
    else if (en_i) q_r <= q_r + W'(1);
  end

  assign q_o  = q_r;
  assign cy_o = en_i & (&q_r);
endmodule

// File: rtl/crs_divider.sv
module crs_divider #(
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned STAGE_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  output logic [DIV_W-1:0] cnt_o
);
  localparam int unsigned NSTAGE = DIV_W / STAGE_W;

  logic [NSTAGE:0] carry;
  assign carry[0] = 1'b1;

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    crs_cnt_stage #(.W(STAGE_W)) stage_i (
      .clk  (clk),
      .rst  (rst),
      .en_i (carry[s]),
      .q_o  (cnt_o[s*STAGE_W +: STAGE_W]),
      .cy_o (carry[s+1])
    );
  end

  logic unused_carry;
  assign unused_carry = carry[NSTAGE];

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> cnt_o == $past(cnt_o) + DIV_W'(1));
endmodule

// File: rtl/crs_ctrl_reg.sv
module crs_ctrl_reg
  import crs_pkg::*;
#(
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned FLAG_BIT = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_n,
  input  logic [BUS_W-1:0]     bus_data,
  output crs_ctrl_t            ctrl_o,
  output logic [CRS_SEL_W-1:0] rate_nxt_o
);
  crs_ctrl_t ctrl_q, ctrl_d;

  always_comb begin
    ctrl_d = ctrl_q;
    if (!wr_n) begin
      ctrl_d.rate = bus_data[CRS_SEL_W-1:0];
      ctrl_d.flag = bus_data[FLAG_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q.rate <= '1;
      ctrl_q.flag <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign rate_nxt_o = ctrl_d.rate;

  logic unused_bus;
  assign unused_bus = ^{bus_data[BUS_W-1:FLAG_BIT+1], bus_data[FLAG_BIT-1:CRS_SEL_W]};

  // R5
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_n && !rst) |=> $stable(ctrl_o));

  // R5
  ctrl_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !rst) |=> (ctrl_o.rate == $past(bus_data[CRS_SEL_W-1:0]))
                     && (ctrl_o.flag == $past(bus_data[FLAG_BIT])));
endmodule

// File: rtl/crs_tap_out.sv
module crs_tap_out
  import crs_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 halt,
  input  logic [DIV_W-1:0]     cnt_i,
  input  logic [CRS_SEL_W-1:0] rate_i,
  input  logic [CRS_SEL_W-1:0] rate_nxt_i,
  output logic                 clk_out,
  output logic                 clk_out_n,
  output logic                 rate_ce
);
  localparam int unsigned NTAP = DIV_W;

  logic [NTAP-1:0] tap_lvl;   // level of each tap now
  logic [NTAP-1:0] tap_nxt;   // level of each tap just after the next edge
  logic [NTAP-1:0] tap_rise;  // tap goes 0 -> 1 at the next edge

  for (genvar i = 0; i < NTAP; i++) begin : g_tap
    if (i == NTAP - 1) begin : g_base
      assign tap_lvl[i]  = clk;
      assign tap_nxt[i]  = 1'b1;
      assign tap_rise[i] = 1'b1;
    end else begin : g_div
      localparam int unsigned B = NTAP - 1 - i;
      assign tap_lvl[i]  = cnt_i[B];
      assign tap_nxt[i]  = cnt_i[B] ^ (&cnt_i[B-1:0]);
      assign tap_rise[i] = ~cnt_i[B] & (&cnt_i[B-1:0]);
    end
  end

  logic run_q, hold_q, ce_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b1;
      hold_q <= 1'b1;
      ce_q   <= 1'b0;
    end else begin
      run_q <= ~halt;
      if (run_q) hold_q <= tap_nxt[rate_nxt_i];
      ce_q  <= ~halt & tap_rise[rate_nxt_i];
    end
  end

  logic sel_lvl;
  assign sel_lvl   = run_q ? tap_lvl[rate_i] : hold_q;
  assign clk_out   = sel_lvl;
  assign clk_out_n = ~sel_lvl;
  assign rate_ce   = ce_q;

  // R8
  ce_halt_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && !rst) |=> !rate_ce);

  // R7
  halt_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (halt && $past(halt) && $past(!rst)) |=> $stable(clk_out) && $stable(clk_out_n));

  // R8
  ce_base_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && !halt && rate_nxt_i == CRS_SEL_W'(NTAP - 1)) |=> rate_ce);
endmodule

// File: rtl/clkrate_sel.sv
module clkrate_sel
  import crs_pkg::*;
#(
  parameter int unsigned STAGE_W  = 4,
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned FLAG_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             wr_n,
  input  logic             halt,
  output logic             clk_out,
  output logic             clk_out_n,
  output logic             rate_ce,
  output logic             disp_flag
);
  localparam int unsigned DIV_W = CRS_NTAP;

  logic [DIV_W-1:0]     cnt;
  crs_ctrl_t            ctrl;
  logic [CRS_SEL_W-1:0] rate_nxt;

  crs_divider #(.DIV_W(DIV_W), .STAGE_W(STAGE_W)) div_i (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (cnt)
  );

  crs_ctrl_reg #(.BUS_W(BUS_W), .FLAG_BIT(FLAG_BIT)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .wr_n       (wr_n),
    .bus_data   (bus_data),
    .ctrl_o     (ctrl),
    .rate_nxt_o (rate_nxt)
  );

  crs_tap_out #(.DIV_W(DIV_W)) out_i (
    .clk        (clk),
    .rst        (rst),
    .halt       (halt),
    .cnt_i      (cnt),
    .rate_i     (ctrl.rate),
    .rate_nxt_i (rate_nxt),
    .clk_out    (clk_out),
    .clk_out_n  (clk_out_n),
    .rate_ce    (rate_ce)
  );

  assign disp_flag = ctrl.flag;
endmodule

// File: tb/clkrate_sel_tb.sv
module clkrate_sel_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_data = 8'h00;
  logic       wr_n = 1'b1;
  logic       halt = 1'b0;
  logic       clk_out, clk_out_n, rate_ce, disp_flag;

  clkrate_sel dut_i (
    .clk(clk), .rst(rst), .bus_data(bus_data), .wr_n(wr_n), .halt(halt),
    .clk_out(clk_out), .clk_out_n(clk_out_n), .rate_ce(rate_ce), .disp_flag(disp_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  bit    chk_en = 1'b0;
  string tag = "R1";

  // Arithmetic model of the requirements, updated at each rising edge.
  logic [7:0] m_cnt;
  logic [2:0] m_sel;
  logic       m_flag, m_run, m_hold, m_ce;

  always @(posedge clk) begin
    logic [2:0] nsel;
    logic [7:0] ncnt;
    int         b;
    if (rst) begin
      m_cnt <= 8'd0; m_sel <= 3'd7; m_flag <= 1'b0;
      m_run <= 1'b1; m_hold <= 1'b1; m_ce <= 1'b0;
    end else begin
      nsel = wr_n ? m_sel : bus_data[2:0];
      ncnt = m_cnt + 8'd1;
      b    = 7 - int'(nsel);
      if (!wr_n) begin
        m_sel <= bus_data[2:0];
        m_flag <= bus_data[3];
      end
      m_cnt <= ncnt;
      if (m_run) m_hold <= (nsel == 3'd7) ? 1'b1 : ncnt[b];
      m_run <= !halt;
      m_ce  <= !halt && ((nsel == 3'd7) || (ncnt[b] && !m_cnt[b]));
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic sample(input logic clk_lvl);
    int exp_out;
    if (m_run) exp_out = (m_sel == 3'd7) ? int'(clk_lvl) : int'(m_cnt[7 - int'(m_sel)]);
    else       exp_out = int'(m_hold);
    chk(tag, int'(clk_out), exp_out);
    chk("R6 clk_out_n", int'(clk_out_n), 1 - exp_out);
    chk("R8 rate_ce", int'(rate_ce), int'(m_ce));
    chk("R5 disp_flag", int'(disp_flag), int'(m_flag));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (chk_en) sample(1'b1);
      #5;
      if (chk_en) sample(1'b0);
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk);
    bus_data = v;
    wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
  endtask

  initial begin
    run(3);
    chk_en = 1'b1;
    rst = 1'b0;
    // R1: reset state, base rate, flag clear, no enable pulse yet
    #3;
    chk("R1 clk_out base after reset", int'(clk_out), int'(clk));
    chk("R1 disp_flag", int'(disp_flag), 0);
    chk("R1 rate_ce", int'(rate_ce), 0);
    run(20);
    tag = "R4";
    run(20);
    // R3 / R9 / R2: every divided rate, long enough for two wraps of the slowest tap
    for (int k = 0; k < 7; k++) begin
      tag = "R9";
      wr(8'(k));
      run(3);
      tag = (k == 0) ? "R2" : "R3";
      run(600);
    end
    tag = "R4";
    wr(8'h07);
    run(30);
    // R5: upper bits ignored, strobe high ignores the bus
    tag = "R5";
    wr(8'hF5);
    run(10);
    bus_data = 8'h0A;
    run(50);
    bus_data = 8'hFE;
    run(20);
    wr(8'h0E);
    run(70);
    // R7: halt at a divided rate, write during halt, release
    tag = "R7";
    wr(8'h03);
    run(37);
    halt = 1'b1;
    run(45);
    wr(8'h05);
    run(20);
    halt = 1'b0;
    run(100);
    // R7: halt at base rate
    wr(8'h07);
    run(5);
    halt = 1'b1;
    run(12);
    halt = 1'b0;
    run(10);
    // R7: short halt pulse at slow rate
    wr(8'h01);
    run(9);
    halt = 1'b1;
    run(1);
    halt = 1'b0;
    run(80);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule